// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

This block takes a snapshot of a free-running timer when an event is seen on an external input pin. The pin is asynchronous to the block clock. It first passes through a synchronizer chain, then through an edge detector. A qualifier then picks the events that count, based on a 4-bit mode field. The qualifier can accept every falling edge, every rising edge, every fourth rising edge, or every sixteenth rising edge.

Each qualified event copies the timer value into a holding register. It also sets a sticky interrupt flag, which software clears with a one-cycle strobe. A new capture replaces the held value whether or not it was read.

The edge counter behind the divide settings is zeroed only on reset and while the mode field holds a non-capture code. Moving directly from one capture setting to another keeps the count. As a result, the first capture after such a move can come early, and can raise a flag that was not intended.

Top module: `tcap_top`

## Requirements
- R1: After reset the held value is 0 and the flag is 0.
- R2: With mode 4'b0100, every falling edge of the pin causes a capture.
- R3: With mode 4'b0101, every rising edge of the pin causes a capture, and falling edges cause none.
- R4: With mode 4'b0110, a capture happens on each rising edge that makes the edge count a multiple of 4. With mode 4'b0111, a capture happens on each rising edge that makes the count a multiple of 16.
- R5: Once set, the flag stays set until a cycle with the clear strobe high and no capture. If a capture and a clear land on the same edge, the flag is set.
- R6: Each capture overwrites the held value, even if the flag is already set.
- R7: Any mode outside 4'b0100..4'b0111 (4'b0000 = off) causes no capture and zeroes the edge counter.
- R8: A direct change between capture modes keeps the edge count. The next divided capture is counted from that stale value.
- R9: A pin level first sampled at clock edge k is captured at edge k+3. The held value is the timer input present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_async | input | 1 | Asynchronous event pin |
| timer_val | input | 16 | Current free-running timer value |
| mode | input | 4 | Capture mode select |
| flag_clr | input | 1 | Software clear strobe for the flag |
| hold_val | output | 16 | Last captured timer value |
| irq_flag | output | 1 | Sticky capture flag |

## Verification
The pin is driven with pulses of random width in each capture mode. Falling-edge and rising-edge modes are told apart by asymmetric pulse widths: the two modes capture at different timer values. The divide-by-4 and divide-by-16 runs use long pulse trains to show that captures appear only at the right edge counts. Mode switches in the middle of a train, with no pass through off, show that the stale count is kept. An off interlude shows that the count is cleared. A clear strobe held high across captures probes the case where capture and clear land on the same edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
   localparam int TMR_W_DEF = 16;
   localparam int MODE_W    = 4;

   typedef enum logic [MODE_W-1:0] {
      CM_OFF    = 4'b0000,
      CM_FALL   = 4'b0100,
      CM_RISE   = 4'b0101,
      CM_DIVMID = 4'b0110,
      CM_DIVHI  = 4'b0111
   } cap_mode_e;

   function automatic logic mode_is_capture(logic [MODE_W-1:0] m);
      return m[3:2] == 2'b01;
   endfunction

   function automatic logic is_pow2(int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tcap_edge.sv
module tcap_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise,
   output logic fall
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tcap_edge: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= pin_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~last_q;
   assign fall = ~sync_q[SYNC_STAGES-1] & last_q;

   AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall)); // R3
   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R3
   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R2
endmodule

// File: rtl/tcap_prescale.sv
module tcap_prescale
   import tcap_pkg::*;
#(
   parameter int DIV_MID = 4,
   parameter int DIV_HI  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              rise,
   input  logic              fall,
   output logic              qual
);
   localparam int CNT_W = $clog2(DIV_HI);
   localparam int MID_W = $clog2(DIV_MID);

   if (!is_pow2(DIV_MID) || DIV_MID < 2) begin : g_bad_mid
      $error("tcap_prescale: DIV_MID must be a power of two of at least 2");
   end
   if (!is_pow2(DIV_HI) || DIV_HI <= DIV_MID) begin : g_bad_hi
      $error("tcap_prescale: DIV_HI must be a power of two above DIV_MID");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             cap_on;
   logic             sel_edge;
   logic             mid_hit;
   logic             hi_hit;

   assign cap_on   = mode_is_capture(mode);
   assign sel_edge = (mode == CM_FALL) ? fall : rise;
   assign mid_hit  = (cnt_q[MID_W-1:0] == {MID_W{1'b1}});
   assign hi_hit   = (cnt_q == {CNT_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n || !cap_on) cnt_q <= '0;
      else if (sel_edge)     cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      qual = 1'b0;
      if (cap_on && sel_edge) begin
         unique case (mode)
            CM_FALL, CM_RISE: qual = 1'b1;
            CM_DIVMID:        qual = mid_hit;
            CM_DIVHI:         qual = hi_hit;
            default:          qual = 1'b0;
         endcase
      end
   end

   AST_PSC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_on |=> (cnt_q == '0)); // R7
   AST_PSC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_on && !sel_edge && mode_is_capture($past(mode))) |=> $stable(cnt_q)); // R8
   AST_NO_QUAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_on |-> !qual); // R7
endmodule

// File: rtl/tcap_hold.sv
module tcap_hold #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual,
   input  logic [TMR_W-1:0] timer_val,
   input  logic             flag_clr,
   output logic [TMR_W-1:0] hold_val,
   output logic             irq_flag
);
   if (TMR_W < 2) begin : g_bad_w
      $error("tcap_hold: TMR_W must be at least 2");
   end

   logic evt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= qual;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     hold_val <= '0;
      else if (evt_q) hold_val <= timer_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        irq_flag <= 1'b0;
      else if (evt_q)    irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
   end

   AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |=> irq_flag); // R5
   AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q |=> (hold_val == $past(timer_val))); // R6
   AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_q |=> $stable(hold_val)); // R9
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag); // R5
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !evt_q) |=> !irq_flag); // R5
endmodule

// File: rtl/tcap_top.sv
module tcap_top
   import tcap_pkg::*;
#(
   parameter int TMR_W       = TMR_W_DEF,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_MID     = 4,
   parameter int DIV_HI      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_async,
   input  logic [TMR_W-1:0]  timer_val,
   input  logic [MODE_W-1:0] mode,
   input  logic              flag_clr,
   output logic [TMR_W-1:0]  hold_val,
   output logic              irq_flag
);
   logic rise;
   logic fall;
   logic qual;

   tcap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin_async),
      .rise      (rise),
      .fall      (fall)
   );

   tcap_prescale #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .rise  (rise),
      .fall  (fall),
      .qual  (qual)
   );

   tcap_hold #(.TMR_W(TMR_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual      (qual),
      .timer_val (timer_val),
      .flag_clr  (flag_clr),
      .hold_val  (hold_val),
      .irq_flag  (irq_flag)
   );

   AST_FLAG_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> $past(mode_is_capture(mode), 2)); // R7
endmodule

// File: tb/tcap_top_tb.sv
`timescale 1ns/1ps
module tcap_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_async = 1'b0;
   logic [15:0] timer_val = 16'h0100;
   logic [3:0]  mode = 4'b0000;
   logic        flag_clr = 1'b0;
   logic [15:0] hold_val;
   logic        irq_flag;

   int n_checks = 0;
   int n_fail = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   // reference state
   bit s1, s2, sprev, mevt, mflag;
   int mcnt;
   logic [15:0] mhold;
   int cap_seen;

   always #2.5 clk = ~clk;

   tcap_top u_dut (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .timer_val(timer_val),
      .mode(mode), .flag_clr(flag_clr), .hold_val(hold_val), .irq_flag(irq_flag)
   );

   always @(negedge clk) timer_val <= timer_val + 16'd3;

   always @(posedge clk) begin
      bit rise, fall, cap, sel, qual;
      if (!rst_n) begin
         s1 = 0; s2 = 0; sprev = 0; mevt = 0; mflag = 0; mcnt = 0; mhold = 0;
      end else begin
         rise = s2 && !sprev;
         fall = !s2 && sprev;
         cap  = (mode[3:2] == 2'b01);
         sel  = (mode == 4'b0100) ? fall : rise;
         qual = 0;
         if (cap && sel) begin
            if (mode == 4'b0100 || mode == 4'b0101) qual = 1;
            else if (mode == 4'b0110) qual = (mcnt % 4 == 3);
            else qual = (mcnt == 15);
         end
         if (mevt) begin mhold = timer_val; mflag = 1; cap_seen++; end
         else if (flag_clr) mflag = 0;
         mevt = qual;
         if (!cap) mcnt = 0;
         else if (sel) mcnt = (mcnt + 1) % 16;
         sprev = s2; s2 = s1; s1 = pin_async;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if (hold_val !== mhold || irq_flag !== mflag) begin
            n_fail++;
            $display("FAIL %s: hold=%h flag=%b expected hold=%h flag=%b",
                     cur_req, hold_val, irq_flag, mhold, mflag);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulses(int count, int hi_min, int hi_max, int lo_min, int lo_max);
      for (int i = 0; i < count; i++) begin
         pin_async = 1'b1; tick($urandom_range(hi_max, hi_min));
         pin_async = 1'b0; tick($urandom_range(lo_max, lo_min));
      end
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1; tick(1); flag_clr = 1'b0; tick(1);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int c0;
      logic [15:0] first;
      void'($urandom(11));
      tick(4);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      check(hold_val == 16'h0 && irq_flag == 1'b0, "R1", {hold_val, 15'b0, irq_flag}, 0);

      // R3 rising edges, asymmetric pulses
      cur_req = "R3"; mode = 4'b0101; tick(3);
      c0 = cap_seen;
      pulses(8, 1, 3, 4, 9); tick(6);
      check(cap_seen - c0 == 8, "R3", cap_seen - c0, 8);
      check(irq_flag == 1'b1, "R3", irq_flag, 1);
      cur_req = "R5"; clear_flag();
      check(irq_flag == 1'b0, "R5", irq_flag, 0);

      // R2 falling edges
      cur_req = "R2"; mode = 4'b0100; tick(3);
      c0 = cap_seen;
      pulses(8, 5, 9, 1, 2); tick(6);
      check(cap_seen - c0 == 8, "R2", cap_seen - c0, 8);
      clear_flag();

      // R7 off clears count; R4 divide by 4
      cur_req = "R7"; mode = 4'b0000; c0 = cap_seen;
      pulses(5, 1, 3, 1, 3); tick(6);
      check(cap_seen == c0 && irq_flag == 1'b0, "R7", cap_seen - c0, 0);
      mode = 4'b1010; pulses(4, 1, 3, 1, 3); tick(6);
      check(cap_seen == c0 && irq_flag == 1'b0, "R7", cap_seen - c0, 0);
      cur_req = "R4"; mode = 4'b0110; tick(2); c0 = cap_seen;
      pulses(12, 1, 4, 1, 4); tick(6);
      check(cap_seen - c0 == 3, "R4", cap_seen - c0, 3);
      mode = 4'b0000; tick(2);
      mode = 4'b0111; tick(2); c0 = cap_seen;
      pulses(32, 1, 2, 1, 2); tick(6);
      check(cap_seen - c0 == 2, "R4", cap_seen - c0, 2);

      // R6 overwrite without clear
      cur_req = "R6"; mode = 4'b0101; tick(2);
      pulses(1, 2, 2, 6, 6); tick(4); first = hold_val;
      pulses(1, 2, 2, 6, 6); tick(4);
      check(hold_val != first && irq_flag == 1'b1, "R6", hold_val, first + 24);
      clear_flag();

      // R8 direct switch keeps stale count: 2 rises in /4, then /16
      cur_req = "R8"; mode = 4'b0000; tick(2); mode = 4'b0110; tick(2);
      pulses(2, 2, 2, 2, 2); tick(4);
      mode = 4'b0111; c0 = cap_seen;
      pulses(14, 2, 2, 2, 2); tick(6);
      check(cap_seen - c0 == 1, "R8", cap_seen - c0, 1);
      mode = 4'b0110; pulses(5, 1, 3, 1, 3); tick(6);
      clear_flag();

      // R5 capture and clear on the same edge: clear held high throughout
      cur_req = "R5"; mode = 4'b0101; flag_clr = 1'b1; tick(2);
      pulses(6, 1, 3, 1, 3); tick(6);
      flag_clr = 1'b0; tick(2);

      // R9 latency: pin sampled at edge k, capture at edge k+3
      cur_req = "R9"; clear_flag();
      @(negedge clk); pin_async = 1'b1;
      @(posedge clk); #1; check(irq_flag == 1'b0, "R9", irq_flag, 0);
      tick(2); check(irq_flag == 1'b0, "R9", irq_flag, 0);
      tick(1); check(irq_flag == 1'b1, "R9", irq_flag, 1);
      pin_async = 1'b0; tick(8);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule